// File: doc/BRIEF.md
# IR Receive Symbol FIFO and Interrupt Status Block

This block sits between an infrared pulse sampler and a processor's register bus. The sampler hands it one byte per measured run, with the level in the top bit and the run length in the low seven bits. It also sends a one-cycle pulse when it sees a packet end. The block stores the bytes in a first-in first-out buffer whose depth is a parameter (16 or 64 entries). Software drains the buffer by reading the data register, and every read of that register removes the oldest byte.

Three sticky event flags record buffer overflow, packet end and data availability. Data availability is judged against a programmable fill threshold. Software clears each flag by writing a one to its bit. A single interrupt line is the OR of every flag that is also enabled. The block also keeps the control, receive-configuration and sample-configuration settings that the sampler needs, and drives them to it on output ports.

Top module: `irrx_fifo_irq`

## Requirements
- R1: After reset every register reads zero, the fill count is zero, no flag is set and `irq` is low.
- R2: Symbol writes and packet-end pulses are accepted only while control bit 0 (block on) and control bit 1 (receiver on) are both one; otherwise they change neither the fill count nor any flag.
- R3: A read at offset 0x20 returns the oldest stored byte in bits 7:0 and removes it in the same cycle. A read of an empty buffer returns zero and leaves the count at zero.
- R4: The status word at offset 0x30 carries the live fill count in the field starting at bit 8, which is $clog2(DEPTH)+1 bits wide.
- R5: A symbol that arrives while the buffer holds DEPTH bytes is dropped and sets status bit 0 (overflow). The count stays at DEPTH and the stored bytes are unchanged.
- R6: An accepted packet-end pulse sets status bit 1 on the next clock edge.
- R7: Status bit 4 (data available) becomes set one cycle after the fill count exceeds the threshold field at bit 8 of the interrupt-enable register (offset 0x2C).
- R8: Writing the status word clears exactly those flags whose bit is one; 0xFF clears all of them. In the cycle after a clear the flag reads zero, and it sets again one cycle later if its condition still holds.
- R9: `irq` is high exactly when some flag is set whose enable bit at the same position (0, 1 or 4) of the interrupt-enable register is one.
- R10: The configuration registers read back only their defined fields and drive the sampler ports. The control register at 0x00 holds bits 0, 1 and 5:4 (5:4 drive `cir_mode`). The receive configuration at 0x10 holds bit 2 (`rx_invert`). The sample configuration at 0x34 holds bits 7:2 (`noise_thr`) and bits 15:8 (`idle_thr`). Undefined bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | Sampler presents a symbol byte this cycle |
| sym_data | input | 8 | Symbol byte: level in bit 7, run length in bits 6:0 |
| pkt_end | input | 1 | One-cycle packet-end pulse from the sampler |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (pops the buffer at offset 0x20) |
| reg_rdata | output | 32 | Register read data for the addressed register |
| irq | output | 1 | Interrupt request |
| cir_mode | output | 2 | Mode field for the sampler |
| rx_invert | output | 1 | Input polarity inversion for the sampler |
| noise_thr | output | 6 | Noise threshold for the sampler |
| idle_thr | output | 8 | Idle threshold for the sampler |

## Verification
The bound checker examines every cycle. It checks that the count never goes above the depth and never rises while the receiver is off. It checks that a full buffer drops a symbol and records overflow, and that a packet end or a count above the threshold sets the matching flag one cycle later. It also checks that a write of one clears a flag for the following cycle and that `irq` stays low when no enabled flag is set. Only the bench scenarios can show that the bytes come out in arrival order and with the right values, that an overflowed byte never appears, and that the status word packs the flags and count in the stated bit positions. The same holds for the readback masks of the configuration registers and the sequence in which a cleared flag drops and then returns.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_RXCFG = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_SAMP  = 6'h34;

  // bit positions inside status and interrupt-enable words
  localparam int POS_OVF = 0;
  localparam int POS_PKT = 1;
  localparam int POS_DAV = 4;
  localparam int POS_CNT = 8;

  // index of each event inside the packed flag vector
  localparam int EV_OVF = 0;
  localparam int EV_PKT = 1;
  localparam int EV_DAV = 2;
  localparam int N_EV   = 3;

  typedef struct packed {
    logic [1:0] mode;
    logic       rx_on;
    logic       blk_on;
  } ctrl_t;

  typedef struct packed {
    logic [5:0] noise;
    logic [7:0] idle;
  } samp_t;
endpackage

// File: rtl/irrx_sym_fifo.sv
module irrx_sym_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage carries no reset; only written entries are ever read out
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

  assign head  = mem[rd_ptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/irrx_evt_flags.sv
module irrx_evt_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_ev,
  input  logic [NF-1:0] clr_ev,
  output logic [NF-1:0] flags
);
  logic [NF-1:0] flg_q, flg_d;

  for (genvar g = 0; g < NF; g++) begin : g_flag
    // a clear wins in its own cycle; a standing condition re-sets afterwards
    always_comb begin
      if (clr_ev[g]) flg_d[g] = 1'b0;
      else           flg_d[g] = flg_q[g] | set_ev[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags = flg_q;
endmodule

// File: rtl/irrx_cfg_regs.sv
module irrx_cfg_regs
  import irrx_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output ctrl_t             ctrl,
  output logic              invert,
  output samp_t             samp,
  output logic [N_EV-1:0]   ien,
  output logic [CNT_W-1:0]  trig
);
  ctrl_t            ctrl_q, ctrl_d;
  logic             inv_q, inv_d;
  samp_t            samp_q, samp_d;
  logic [N_EV-1:0]  ien_q, ien_d;
  logic [CNT_W-1:0] trig_q, trig_d;
  logic             wdata_unused;

  assign wdata_unused = ^wdata[31:16];

  always_comb begin
    ctrl_d = ctrl_q;
    inv_d  = inv_q;
    samp_d = samp_q;
    ien_d  = ien_q;
    trig_d = trig_q;
    if (wr) begin
      case (addr)
        OFS_CTRL: begin
          ctrl_d.blk_on = wdata[0];
          ctrl_d.rx_on  = wdata[1];
          ctrl_d.mode   = wdata[5:4];
        end
        OFS_RXCFG: inv_d = wdata[2];
        OFS_IEN: begin
          ien_d[EV_OVF] = wdata[POS_OVF];
          ien_d[EV_PKT] = wdata[POS_PKT];
          ien_d[EV_DAV] = wdata[POS_DAV];
          trig_d        = wdata[POS_CNT +: CNT_W];
        end
        OFS_SAMP: begin
          samp_d.noise = wdata[7:2];
          samp_d.idle  = wdata[15:8];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      inv_q  <= 1'b0;
      samp_q <= '0;
      ien_q  <= '0;
      trig_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      inv_q  <= inv_d;
      samp_q <= samp_d;
      ien_q  <= ien_d;
      trig_q <= trig_d;
    end
  end

  assign ctrl   = ctrl_q;
  assign invert = inv_q;
  assign samp   = samp_q;
  assign ien    = ien_q;
  assign trig   = trig_q;
endmodule

// File: rtl/irrx_fifo_irq.sv
module irrx_fifo_irq
  import irrx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  logic [7:0]        sym_data,
  input  logic              pkt_end,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic [1:0]        cir_mode,
  output logic              rx_invert,
  output logic [5:0]        noise_thr,
  output logic [7:0]        idle_thr
);
  // asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ctrl_t            ctrl_v;
  samp_t            samp_v;
  logic             inv_v;
  logic [N_EV-1:0]  ien_mask;
  logic [CNT_W-1:0] trig_lvl;

  irrx_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .ctrl   (ctrl_v),
    .invert (inv_v),
    .samp   (samp_v),
    .ien    (ien_mask),
    .trig   (trig_lvl)
  );

  logic             rx_live;
  logic             fifo_push, fifo_pop;
  logic [7:0]       fifo_head;
  logic [CNT_W-1:0] fill_cnt;
  logic             fifo_full, fifo_empty;

  assign rx_live   = ctrl_v.blk_on && ctrl_v.rx_on;
  assign fifo_push = rx_live && sym_valid;
  assign fifo_pop  = reg_rd && (reg_addr == OFS_DATA);

  irrx_sym_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (fifo_push),
    .din   (sym_data),
    .pop   (fifo_pop),
    .head  (fifo_head),
    .count (fill_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  logic [N_EV-1:0] ev_set, ev_clr, flag_q;
  logic            stat_wr;

  assign stat_wr = reg_wr && (reg_addr == OFS_STAT);

  always_comb begin
    ev_set         = '0;
    ev_set[EV_OVF] = fifo_push && fifo_full;
    ev_set[EV_PKT] = rx_live && pkt_end;
    ev_set[EV_DAV] = (fill_cnt > trig_lvl);
    ev_clr         = '0;
    ev_clr[EV_OVF] = stat_wr && reg_wdata[POS_OVF];
    ev_clr[EV_PKT] = stat_wr && reg_wdata[POS_PKT];
    ev_clr[EV_DAV] = stat_wr && reg_wdata[POS_DAV];
  end

  irrx_evt_flags #(.NF(N_EV)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_ev (ev_set),
    .clr_ev (ev_clr),
    .flags  (flag_q)
  );

  assign irq = |(flag_q & ien_mask);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[0]   = ctrl_v.blk_on;
        reg_rdata[1]   = ctrl_v.rx_on;
        reg_rdata[5:4] = ctrl_v.mode;
      end
      OFS_RXCFG: reg_rdata[2] = inv_v;
      OFS_DATA:  reg_rdata[7:0] = fifo_empty ? 8'h00 : fifo_head;
      OFS_IEN: begin
        reg_rdata[POS_OVF]          = ien_mask[EV_OVF];
        reg_rdata[POS_PKT]          = ien_mask[EV_PKT];
        reg_rdata[POS_DAV]          = ien_mask[EV_DAV];
        reg_rdata[POS_CNT +: CNT_W] = trig_lvl;
      end
      OFS_STAT: begin
        reg_rdata[POS_OVF]          = flag_q[EV_OVF];
        reg_rdata[POS_PKT]          = flag_q[EV_PKT];
        reg_rdata[POS_DAV]          = flag_q[EV_DAV];
        reg_rdata[POS_CNT +: CNT_W] = fill_cnt;
      end
      OFS_SAMP: begin
        reg_rdata[7:2]  = samp_v.noise;
        reg_rdata[15:8] = samp_v.idle;
      end
      default: ;
    endcase
  end

  assign cir_mode  = ctrl_v.mode;
  assign rx_invert = inv_v;
  assign noise_thr = samp_v.noise;
  assign idle_thr  = samp_v.idle;
endmodule

// File: rtl/irrx_fifo_irq_chk.sv
module irrx_fifo_irq_chk
  import irrx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sym_valid,
  input logic              pkt_end,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [31:0]       reg_wdata,
  input logic              irq,
  input logic              rx_live,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  trig,
  input logic [N_EV-1:0]   flags,
  input logic [N_EV-1:0]   ien
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic chk_unused;
  assign chk_unused = ^reg_wdata[31:5] ^ reg_wdata[3] ^ reg_wdata[2];

  logic stw, popr;
  assign stw  = reg_wr && (reg_addr == OFS_STAT);
  assign popr = reg_rd && (reg_addr == OFS_DATA);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_live && sym_valid && count == FULL_CNT && !popr) |=> (count == FULL_CNT));

  assert_overflow_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_live && sym_valid && count == FULL_CNT && !(stw && reg_wdata[POS_OVF]))
      |=> flags[EV_OVF]);

  assert_no_growth_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_live |=> (count <= $past(count)));

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (popr && count == '0 && !(rx_live && sym_valid)) |=> (count == '0));

  assert_pkt_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_live && pkt_end && !(stw && reg_wdata[POS_PKT])) |=> flags[EV_PKT]);

  assert_dav_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count > trig && !(stw && reg_wdata[POS_DAV])) |=> flags[EV_DAV]);

  assert_w1c_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stw && reg_wdata[POS_OVF]) |=> !flags[EV_OVF]);

  assert_w1c_dav_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stw && reg_wdata[POS_DAV]) |=> !flags[EV_DAV]);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(flags & ien) == 0) |-> !irq);
endmodule

bind irrx_fifo_irq irrx_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sym_valid (sym_valid),
  .pkt_end   (pkt_end),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .rx_live   (rx_live),
  .count     (fill_cnt),
  .trig      (trig_lvl),
  .flags     (flag_q),
  .ien       (ien_mask)
);

// File: tb/tb_irrx_fifo_irq.sv
module tb_irrx_fifo_irq;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  localparam logic [5:0] A_CTRL = 6'h00, A_RXC = 6'h10, A_DATA = 6'h20,
                         A_IEN = 6'h2C, A_STAT = 6'h30, A_SAMP = 6'h34;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sym_valid, pkt_end, reg_wr, reg_rd;
  logic [7:0]  sym_data;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, rx_invert;
  logic [1:0]  cir_mode;
  logic [5:0]  noise_thr;
  logic [7:0]  idle_thr;

  always #10 clk = ~clk;

  irrx_fifo_irq #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
    .pkt_end(pkt_end), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .irq(irq), .cir_mode(cir_mode), .rx_invert(rx_invert),
    .noise_thr(noise_thr), .idle_thr(idle_thr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  function automatic logic [31:0] exp_stat(int cnt, bit ovf, bit pkt, bit dav);
    logic [31:0] w = '0;
    w[0] = ovf;
    w[1] = pkt;
    w[4] = dav;
    w[8 +: CNT_W] = CNT_W'(cnt);
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    sym_valid = 1'b1; sym_data = b;
    @(negedge clk); sym_valid = 1'b0;
  endtask

  task automatic pulse_end();
    pkt_end = 1'b1;
    @(negedge clk); pkt_end = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  mq[$];
    bit          m_ovf, m_dav;
    void'($urandom(32'd4242));
    sym_valid = 0; pkt_end = 0; reg_wr = 0; reg_rd = 0;
    sym_data = '0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    rd(A_STAT, d); chk(d == 32'h0, "R1 status", d, 32'h0);
    rd(A_CTRL, d); chk(d == 32'h0, "R1 control", d, 32'h0);
    rd(A_IEN, d);  chk(d == 32'h0, "R1 int enable", d, 32'h0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 32'h0);

    // R10: field masks and sampler outputs
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d);
    chk(d == 32'h33, "R10 control readback", d, 32'h33);
    chk(cir_mode == 2'b11, "R10 cir_mode", 32'(cir_mode), 32'h3);
    wr(A_RXC, 32'hFFFF_FFFF); rd(A_RXC, d);
    chk(d == 32'h4 && rx_invert, "R10 rx config", d, 32'h4);
    wr(A_SAMP, 32'hFFFF_FFFF); rd(A_SAMP, d);
    chk(d == 32'hFFFC, "R10 sample config", d, 32'hFFFC);
    chk(noise_thr == 6'h3F && idle_thr == 8'hFF, "R10 thresholds",
        {16'h0, idle_thr, 2'b0, noise_thr}, 32'h0000_FF3F);
    wr(A_SAMP, 32'h0000_5A14); rd(A_SAMP, d);
    chk(noise_thr == 6'h05 && idle_thr == 8'h5A, "R10 thresholds pattern",
        {16'h0, idle_thr, 2'b0, noise_thr}, 32'h0000_5A05);
    wr(A_IEN, 32'hFFFF_FFFF); rd(A_IEN, d);
    chk(d == 32'h0000_1F13, "R10 int enable readback", d, 32'h0000_1F13);
    wr(A_IEN, 32'h0000_0000);

    // R2: receiver off ignores symbols and packet end
    wr(A_CTRL, 32'h30);
    push(8'h11); push(8'h22); pulse_end(); idle(1);
    rd(A_STAT, d); chk(d == exp_stat(0, 0, 0, 0), "R2 both off", d, exp_stat(0, 0, 0, 0));
    wr(A_CTRL, 32'h01);
    push(8'h33); pulse_end(); idle(1);
    rd(A_STAT, d); chk(d == exp_stat(0, 0, 0, 0), "R2 rx off", d, exp_stat(0, 0, 0, 0));
    wr(A_CTRL, 32'h02);
    push(8'h44); idle(1);
    rd(A_STAT, d); chk(d == exp_stat(0, 0, 0, 0), "R2 block off", d, exp_stat(0, 0, 0, 0));

    // R3/R4: ordering and count; trigger high so data-available stays clear
    wr(A_IEN, 32'h0000_0F00);
    wr(A_CTRL, 32'h33);
    push(8'hA1); push(8'h7F); push(8'h80);
    rd(A_STAT, d); chk(d == exp_stat(3, 0, 0, 0), "R4 count three", d, exp_stat(3, 0, 0, 0));
    rd(A_DATA, d); chk(d == 32'hA1, "R3 first byte", d, 32'hA1);
    rd(A_STAT, d); chk(d == exp_stat(2, 0, 0, 0), "R4 count after pop", d, exp_stat(2, 0, 0, 0));
    rd(A_DATA, d); chk(d == 32'h7F, "R3 second byte", d, 32'h7F);
    rd(A_DATA, d); chk(d == 32'h80, "R3 third byte", d, 32'h80);
    rd(A_DATA, d); chk(d == 32'h0, "R3 empty read", d, 32'h0);
    rd(A_STAT, d); chk(d == exp_stat(0, 0, 0, 0), "R3 empty count", d, exp_stat(0, 0, 0, 0));

    // R6/R8/R9: packet end, selective clear, interrupt masking
    pulse_end();
    rd(A_STAT, d); chk(d == exp_stat(0, 0, 1, 0), "R6 packet end", d, exp_stat(0, 0, 1, 0));
    chk(irq == 1'b0, "R9 masked", 32'(irq), 32'h0);
    wr(A_IEN, 32'h0000_0F02);
    chk(irq == 1'b1, "R9 enabled", 32'(irq), 32'h1);
    wr(A_STAT, 32'h0000_0011);
    rd(A_STAT, d); chk(d == exp_stat(0, 0, 1, 0), "R8 other bits kept", d, exp_stat(0, 0, 1, 0));
    wr(A_STAT, 32'h0000_0002);
    rd(A_STAT, d); chk(d == exp_stat(0, 0, 0, 0), "R8 packet cleared", d, exp_stat(0, 0, 0, 0));
    chk(irq == 1'b0, "R9 after clear", 32'(irq), 32'h0);

    // R7/R8: trigger level 7
    wr(A_IEN, 32'h0000_0700);
    for (int i = 0; i < 7; i++) push(8'(i));
    idle(1);
    rd(A_STAT, d); chk(d == exp_stat(7, 0, 0, 0), "R7 at level", d, exp_stat(7, 0, 0, 0));
    push(8'h07);
    rd(A_STAT, d); chk(d == exp_stat(8, 0, 0, 0), "R7 one cycle latency", d, exp_stat(8, 0, 0, 0));
    idle(1);
    rd(A_STAT, d); chk(d == exp_stat(8, 0, 0, 1), "R7 above level", d, exp_stat(8, 0, 0, 1));
    wr(A_STAT, 32'h0000_0010);
    rd(A_STAT, d); chk(d == exp_stat(8, 0, 0, 0), "R8 dropped after clear", d, exp_stat(8, 0, 0, 0));
    rd(A_STAT, d); chk(d == exp_stat(8, 0, 0, 1), "R8 re-set while held", d, exp_stat(8, 0, 0, 1));
    wr(A_IEN, 32'h0000_0710);
    chk(irq == 1'b1, "R9 data available irq", 32'(irq), 32'h1);
    for (int i = 0; i < 8; i++) begin
      rd(A_DATA, d); chk(d == 32'(i), "R3 drain order", d, 32'(i));
    end
    wr(A_STAT, 32'h0000_00FF); idle(1);
    rd(A_STAT, d); chk(d == exp_stat(0, 0, 0, 0), "R8 stays clear", d, exp_stat(0, 0, 0, 0));

    // R5: overflow
    wr(A_IEN, 32'h0000_1F01);
    for (int i = 0; i < DEPTH; i++) push(8'(8'hC0 + i));
    chk(irq == 1'b0, "R9 full without overflow", 32'(irq), 32'h0);
    push(8'hEE);
    rd(A_STAT, d); chk(d == exp_stat(DEPTH, 1, 0, 0), "R5 overflow", d, exp_stat(DEPTH, 1, 0, 0));
    chk(irq == 1'b1, "R9 overflow irq", 32'(irq), 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_DATA, d); chk(d == 32'(8'hC0 + i), "R5 contents intact", d, 32'(8'hC0 + i));
    end
    rd(A_DATA, d); chk(d == 32'h0, "R5 dropped byte absent", d, 32'h0);
    wr(A_STAT, 32'h0000_00FF);
    rd(A_STAT, d); chk(d == exp_stat(0, 0, 0, 0), "R8 clear all", d, exp_stat(0, 0, 0, 0));
    chk(irq == 1'b0, "R9 cleared", 32'(irq), 32'h0);

    // random mix against a queue model, trigger level 0
    wr(A_IEN, 32'h0);
    m_ovf = 0; m_dav = 0;
    for (int k = 0; k < 400; k++) begin
      int op = int'($urandom % 3);
      if (op != 0) begin
        logic [7:0] b = 8'($urandom);
        if (mq.size() < DEPTH) mq.push_back(b); else m_ovf = 1;
        push(b);
      end else begin
        logic [7:0] e = (mq.size() > 0) ? mq.pop_front() : 8'h00;
        rd(A_DATA, d); chk(d == 32'(e), "R3 random pop", d, 32'(e));
      end
      if (mq.size() > 0) m_dav = 1;
    end
    idle(1);
    rd(A_STAT, d);
    chk(d == exp_stat(mq.size(), m_ovf, 0, m_dav), "R4 random status", d,
        exp_stat(mq.size(), m_ovf, 0, m_dav));

    finish_run();
  end
endmodule